// File: doc/BRIEF.md
# Video Memory DMA Sequencer

This block sequences direct memory transfers into video memory. It runs in one of four modes, selected when a transfer is started. The two load modes fetch 16-bit words from the external bus and hand them to the video write queue. The fill mode waits for a data word to leave that queue and then writes its upper byte across a run of video RAM. The copy mode moves bytes from one part of video RAM to another. The block holds a source address, a destination address with a programmable step, and a count of transfers still to do. It reports when a transfer is outstanding and gives a one-cycle pulse when it ends.

A start strobe loads the mode, length, source, destination and step in one cycle. The engine then moves at most one item per clock. It yields to a full write queue, to a fill word that has not arrived yet, and to video RAM being busy. Load transfers are held back for a fixed settling interval after each start. The register decode in front of the block and the write queue behind it belong to the surrounding design.

Top module: `vdma_seq`

## Requirements
- R1: After reset `xfer_pending` and `xfer_done` are 0, and `bus_req`, `fifo_we`, `vram_re` and `vram_we` stay low while no transfer is pending.
- R2: In load modes (`start_mode` 0 and 1) the bus address is `{start_mode[0], source, 1'b0}`, 24 bits with the mode bit at bit 23. A word is fetched only when no fetched word is held, so a transfer of N words issues exactly N bus reads, even while the queue is full. Each word goes to the queue at the current destination.
- R3: A load start arms a settling count of 7 cycles. The first queue write appears in the 8th cycle after the start edge, and no queue write happens while `fifo_full` is 1.
- R4: A fill start (`start_mode` 2) writes nothing until a `fill_kick` pulse arrives. The word on `fill_word` in that cycle is captured, and its bits [15:8] are written at each destination.
- R5: Fill writes happen only while `fifo_empty` is 1 and `vram_busy` is 0.
- R6: Copy (`start_mode` 3) reads the byte at source XOR 1 and then writes it at destination XOR 1. It makes no access while `vram_busy` is 1, and every access leaves the following cycle free of video RAM access.
- R7: After each transfer only bits [15:0] of the source increment, wrapping from 16'hFFFF to 0 while the upper bits are kept. The destination adds `start_inc`.
- R8: A start length of 0 runs 2^LEN_W transfers.
- R9: `xfer_pending` is 1 from the cycle after a start until the final transfer. `xfer_done` is a single-cycle pulse in the first cycle in which `xfer_pending` is 0 again.
- R10: A start in the same cycle as the final transfer of the previous command takes effect. `xfer_pending` stays 1 and no `xfer_done` pulse is given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_we | input | 1 | Start strobe for a new transfer |
| start_mode | input | 2 | 0/1 load, 2 fill, 3 copy |
| start_len | input | LEN_W | Transfer count (0 means 2^LEN_W) |
| start_src | input | SRC_W | Source word address (load) or byte address (copy) |
| start_dst | input | DST_W | Destination address |
| start_inc | input | INC_W | Destination step |
| fill_kick | input | 1 | Fill word has left the write queue |
| fill_word | input | DATA_W | Word that left the queue |
| bus_req | output | 1 | External bus read this cycle |
| bus_addr | output | SRC_W+2 | External bus byte address |
| bus_rdata | input | DATA_W | Bus read data, same cycle |
| fifo_full | input | 1 | Write queue full |
| fifo_empty | input | 1 | Write queue empty |
| fifo_we | output | 1 | Push to write queue |
| fifo_addr | output | DST_W | Destination of the pushed word |
| fifo_wdata | output | DATA_W | Pushed word |
| vram_busy | input | 1 | Video RAM taken by another agent |
| vram_re | output | 1 | Video RAM byte read |
| vram_raddr | output | DST_W | Read address |
| vram_rdata | input | 8 | Read byte, same cycle |
| vram_we | output | 1 | Video RAM byte write |
| vram_waddr | output | DST_W | Write address |
| vram_wdata | output | 8 | Write byte |
| xfer_pending | output | 1 | Transfer outstanding |
| xfer_done | output | 1 | One-cycle end pulse |

## Verification
The start strobe and the completion of the last transfer can fall in the same cycle. Completion wants to clear the pending flag and raise the end pulse, while the start wants a fresh command. The bench watches a one-word load. In the exact cycle where that single queue write shows on the ports, it drives a new start. One cycle later it requires the pending flag to be high and no end pulse. The scoreboard must then see the second command's words in full.

// File: rtl/vdma_pkg.sv
package vdma_pkg;
   typedef enum logic [1:0] {
      VM_LOAD_LO = 2'd0,
      VM_LOAD_HI = 2'd1,
      VM_FILL    = 2'd2,
      VM_COPY    = 2'd3
   } vdma_mode_e;

   function automatic logic mode_is_load(vdma_mode_e m);
      return (m == VM_LOAD_LO) || (m == VM_LOAD_HI);
   endfunction
endpackage

// File: rtl/vdma_addr_gen.sv
// Source/destination pointers and remaining-transfer counter.
module vdma_addr_gen #(
   parameter int SRC_W  = 22,
   parameter int DST_W  = 16,
   parameter int LEN_W  = 16,
   parameter int INC_W  = 8,
   parameter int WRAP_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [SRC_W-1:0] src_in,
   input  logic [DST_W-1:0] dst_in,
   input  logic [INC_W-1:0] inc_in,
   input  logic [LEN_W-1:0] len_in,
   input  logic             step,
   output logic [SRC_W-1:0] src_q,
   output logic [DST_W-1:0] dst_q,
   output logic             last
);
   localparam int CNT_W = LEN_W + 1;
   localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(1) << LEN_W;

   logic [CNT_W-1:0] cnt_q;
   logic [INC_W-1:0] inc_q;
   logic [SRC_W-1:0] src_nxt;

   // Only the low WRAP_W bits of the source advance.
   generate
      if (SRC_W > WRAP_W) begin : g_split
         assign src_nxt = {src_q[SRC_W-1:WRAP_W], src_q[WRAP_W-1:0] + WRAP_W'(1)};
      end else begin : g_flat
         assign src_nxt = src_q + SRC_W'(1);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         src_q <= '0;
         dst_q <= '0;
         inc_q <= '0;
         cnt_q <= '0;
      end else if (load) begin
         src_q <= src_in;
         dst_q <= dst_in;
         inc_q <= inc_in;
         cnt_q <= (len_in == '0) ? FULL_CNT : CNT_W'(len_in);
      end else if (step) begin
         src_q <= src_nxt;
         dst_q <= dst_q + DST_W'(inc_q);
         cnt_q <= cnt_q - CNT_W'(1);
      end
   end

   assign last = (cnt_q == CNT_W'(1));
endmodule

// File: rtl/vdma_preload.sv
// Settling counter that holds back load pushes after a start.
module vdma_preload #(
   parameter int PRELOAD = 7
) (
   input  logic clk,
   input  logic rst_n,
   input  logic arm,
   input  logic arm_full,
   input  logic clr,
   output logic zero
);
   localparam int PL_W = $clog2(PRELOAD + 2);

   logic [PL_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (arm) begin
         cnt_q <= arm_full ? PL_W'(PRELOAD) : '0;
      end else if (clr) begin
         cnt_q <= '0;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - PL_W'(1);
      end
   end

   assign zero = (cnt_q == '0);
endmodule

// File: rtl/vdma_step_gate.sv
// Per-mode action selection for the current cycle.
module vdma_step_gate
   import vdma_pkg::*;
(
   input  logic       pending,
   input  vdma_mode_e mode,
   input  logic       wait_f,
   input  logic       held,
   input  logic       settled,
   input  logic       fifo_full,
   input  logic       fifo_empty,
   input  logic       ram_busy,
   output logic       do_fetch,
   output logic       do_push,
   output logic       do_fill,
   output logic       do_copy_rd,
   output logic       do_copy_wr,
   output logic       step
);
   logic live;

   always_comb begin
      live       = pending && !wait_f;
      do_fetch   = live && mode_is_load(mode) && !held;
      do_push    = live && mode_is_load(mode) && held && !fifo_full && settled;
      do_fill    = live && (mode == VM_FILL) && fifo_empty && !ram_busy;
      do_copy_rd = live && (mode == VM_COPY) && !ram_busy && !held;
      do_copy_wr = live && (mode == VM_COPY) && !ram_busy && held;
      step       = do_push || do_fill || do_copy_wr;
   end
endmodule

// File: rtl/vdma_seq.sv
module vdma_seq
   import vdma_pkg::*;
#(
   parameter int SRC_W   = 22,
   parameter int DST_W   = 16,
   parameter int LEN_W   = 16,
   parameter int INC_W   = 8,
   parameter int DATA_W  = 16,
   parameter int WRAP_W  = 16,
   parameter int PRELOAD = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_we,
   input  logic [1:0]        start_mode,
   input  logic [LEN_W-1:0]  start_len,
   input  logic [SRC_W-1:0]  start_src,
   input  logic [DST_W-1:0]  start_dst,
   input  logic [INC_W-1:0]  start_inc,
   input  logic              fill_kick,
   input  logic [DATA_W-1:0] fill_word,
   output logic              bus_req,
   output logic [SRC_W+1:0]  bus_addr,
   input  logic [DATA_W-1:0] bus_rdata,
   input  logic              fifo_full,
   input  logic              fifo_empty,
   output logic              fifo_we,
   output logic [DST_W-1:0]  fifo_addr,
   output logic [DATA_W-1:0] fifo_wdata,
   input  logic              vram_busy,
   output logic              vram_re,
   output logic [DST_W-1:0]  vram_raddr,
   input  logic [7:0]        vram_rdata,
   output logic              vram_we,
   output logic [DST_W-1:0]  vram_waddr,
   output logic [7:0]        vram_wdata,
   output logic              xfer_pending,
   output logic              xfer_done
);
   // Elaboration-time parameter checks
   generate
      if (SRC_W < DST_W) begin : g_bad_src
         $error("vdma_seq: SRC_W must be at least DST_W");
      end
      if (INC_W > DST_W) begin : g_bad_inc
         $error("vdma_seq: INC_W must not exceed DST_W");
      end
      if (DATA_W < 8) begin : g_bad_data
         $error("vdma_seq: DATA_W must be at least 8");
      end
      if (WRAP_W < 1) begin : g_bad_wrap
         $error("vdma_seq: WRAP_W must be positive");
      end
   endgenerate

   vdma_mode_e        mode_q;
   logic [1:0]        mode_bits;
   logic              pending_q, wait_q, held_q, own_busy_q, done_q;
   logic [DATA_W-1:0] word_q;
   logic [7:0]        byte_q;
   logic [SRC_W-1:0]  src_q;
   logic [DST_W-1:0]  dst_q;
   logic              last, settled, ram_busy;
   logic              do_fetch, do_push, do_fill, do_copy_rd, do_copy_wr, step;
   logic              finish, kick_hit;

   assign mode_bits = mode_q;
   assign ram_busy  = vram_busy || own_busy_q;
   assign finish    = step && last && !start_we;
   assign kick_hit  = fill_kick && pending_q && (mode_q == VM_FILL) && wait_q;

   vdma_addr_gen #(
      .SRC_W (SRC_W), .DST_W (DST_W), .LEN_W (LEN_W),
      .INC_W (INC_W), .WRAP_W(WRAP_W)
   ) u_addr (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (start_we),
      .src_in(start_src),
      .dst_in(start_dst),
      .inc_in(start_inc),
      .len_in(start_len),
      .step  (step && !start_we),
      .src_q (src_q),
      .dst_q (dst_q),
      .last  (last)
   );

   vdma_preload #(.PRELOAD(PRELOAD)) u_pre (
      .clk     (clk),
      .rst_n   (rst_n),
      .arm     (start_we),
      .arm_full(!start_mode[1]),
      .clr     (finish),
      .zero    (settled)
   );

   vdma_step_gate u_gate (
      .pending   (pending_q),
      .mode      (mode_q),
      .wait_f    (wait_q),
      .held      (held_q),
      .settled   (settled),
      .fifo_full (fifo_full),
      .fifo_empty(fifo_empty),
      .ram_busy  (ram_busy),
      .do_fetch  (do_fetch),
      .do_push   (do_push),
      .do_fill   (do_fill),
      .do_copy_rd(do_copy_rd),
      .do_copy_wr(do_copy_wr),
      .step      (step)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q     <= VM_LOAD_LO;
         pending_q  <= 1'b0;
         wait_q     <= 1'b1;
         held_q     <= 1'b0;
         own_busy_q <= 1'b0;
         done_q     <= 1'b0;
         word_q     <= '0;
         byte_q     <= '0;
      end else begin
         done_q     <= 1'b0;
         own_busy_q <= do_fill || do_copy_rd || do_copy_wr;
         if (start_we) begin
            pending_q <= 1'b1;
            mode_q    <= vdma_mode_e'(start_mode);
            held_q    <= 1'b0;
            wait_q    <= (vdma_mode_e'(start_mode) == VM_FILL);
         end else begin
            if (do_fetch) begin
               held_q <= 1'b1;
               word_q <= bus_rdata;
            end
            if (do_copy_rd) begin
               held_q <= 1'b1;
               byte_q <= vram_rdata;
            end
            if (do_push || do_copy_wr) begin
               held_q <= 1'b0;
            end
            if (kick_hit) begin
               wait_q <= 1'b0;
               word_q <= fill_word;
            end
            if (finish) begin
               pending_q <= 1'b0;
               wait_q    <= 1'b1;
               done_q    <= 1'b1;
            end
         end
      end
   end

   assign bus_req      = do_fetch;
   assign bus_addr     = {mode_bits[0], src_q, 1'b0};
   assign fifo_we      = do_push;
   assign fifo_addr    = dst_q;
   assign fifo_wdata   = word_q;
   assign vram_re      = do_copy_rd;
   assign vram_raddr   = src_q[DST_W-1:0] ^ DST_W'(1);
   assign vram_we      = do_fill || do_copy_wr;
   assign vram_waddr   = do_copy_wr ? (dst_q ^ DST_W'(1)) : dst_q;
   assign vram_wdata   = do_copy_wr ? byte_q : word_q[DATA_W-1 -: 8];
   assign xfer_pending = pending_q;
   assign xfer_done    = done_q;
endmodule

// File: rtl/vdma_seq_chk.sv
module vdma_seq_chk (
   input logic clk,
   input logic rst_n,
   input logic start_we,
   input logic bus_req,
   input logic fifo_we,
   input logic fifo_full,
   input logic vram_busy,
   input logic vram_re,
   input logic vram_we,
   input logic xfer_pending,
   input logic xfer_done
);
   a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !xfer_pending |-> !(bus_req || fifo_we || vram_re || vram_we));

   a_r2_single_fetch: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && !start_we) |=> !bus_req);

   a_r3_no_push_full: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_we |-> !fifo_full);

   a_r5_ram_free: assert property (@(posedge clk) disable iff (!rst_n)
      (vram_we || vram_re) |-> !vram_busy);

   a_r6_access_gap: assert property (@(posedge clk) disable iff (!rst_n)
      (vram_we || vram_re) |=> !(vram_we || vram_re));

   a_r6_one_port: assert property (@(posedge clk) disable iff (!rst_n)
      !(vram_we && vram_re));

   a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_done |=> !xfer_done);

   a_r9_done_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_done |-> $fell(xfer_pending));

   a_r10_fall_gives_done: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(xfer_pending) |-> xfer_done);
endmodule

bind vdma_seq vdma_seq_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .start_we    (start_we),
   .bus_req     (bus_req),
   .fifo_we     (fifo_we),
   .fifo_full   (fifo_full),
   .vram_busy   (vram_busy),
   .vram_re     (vram_re),
   .vram_we     (vram_we),
   .xfer_pending(xfer_pending),
   .xfer_done   (xfer_done)
);

// File: tb/vdma_seq_tb_top.sv
`timescale 1ns/1ps
module vdma_seq_tb_top;
   localparam int SRC_W = 22, DST_W = 16, LEN_W = 10, INC_W = 8, DATA_W = 16;

   logic clk = 1'b0, rst_n = 1'b0;
   logic start_we = 0;
   logic [1:0] start_mode = 0;
   logic [LEN_W-1:0] start_len = 0;
   logic [SRC_W-1:0] start_src = 0;
   logic [DST_W-1:0] start_dst = 0;
   logic [INC_W-1:0] start_inc = 0;
   logic fill_kick = 0;
   logic [DATA_W-1:0] fill_word = 0;
   logic bus_req;
   logic [SRC_W+1:0] bus_addr;
   logic [DATA_W-1:0] bus_rdata;
   logic fifo_full = 0, fifo_empty = 1, fifo_we;
   logic [DST_W-1:0] fifo_addr;
   logic [DATA_W-1:0] fifo_wdata;
   logic vram_busy = 0, vram_re, vram_we;
   logic [DST_W-1:0] vram_raddr, vram_waddr;
   logic [7:0] vram_rdata, vram_wdata;
   logic xfer_pending, xfer_done;

   always #2.5 clk = ~clk;

   function automatic logic [15:0] bus_fn(input logic [23:0] a);
      return a[15:0] ^ {a[23:16], a[23:16]} ^ 16'h5A3C;
   endfunction
   function automatic logic [7:0] vram_fn(input logic [15:0] a);
      return a[7:0] ^ a[15:8] ^ 8'h3C;
   endfunction

   assign bus_rdata  = bus_fn(bus_addr);
   assign vram_rdata = vram_fn(vram_raddr);

   vdma_seq #(.SRC_W(SRC_W), .DST_W(DST_W), .LEN_W(LEN_W), .INC_W(INC_W), .DATA_W(DATA_W)) dut_i (
      .clk(clk), .rst_n(rst_n), .start_we(start_we), .start_mode(start_mode),
      .start_len(start_len), .start_src(start_src), .start_dst(start_dst),
      .start_inc(start_inc), .fill_kick(fill_kick), .fill_word(fill_word),
      .bus_req(bus_req), .bus_addr(bus_addr), .bus_rdata(bus_rdata),
      .fifo_full(fifo_full), .fifo_empty(fifo_empty), .fifo_we(fifo_we),
      .fifo_addr(fifo_addr), .fifo_wdata(fifo_wdata), .vram_busy(vram_busy),
      .vram_re(vram_re), .vram_raddr(vram_raddr), .vram_rdata(vram_rdata),
      .vram_we(vram_we), .vram_waddr(vram_waddr), .vram_wdata(vram_wdata),
      .xfer_pending(xfer_pending), .xfer_done(xfer_done)
   );

   typedef struct {
      bit          to_vram;
      logic [15:0] addr;
      logic [15:0] data;
      string       req;
   } exp_t;
   exp_t sb_q[$];

   int n_chk = 0, n_fail = 0;
   int n_fetch = 0, n_fwr = 0, n_vwr = 0, n_vrd = 0;
   int cyc_total = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic sb_check(input bit to_vram, input logic [15:0] addr, input logic [15:0] data);
      exp_t e;
      if (sb_q.size() == 0) begin
         chk(0, "R2", "unexpected write", {15'd0, to_vram, addr}, 32'h0);
      end else begin
         e = sb_q.pop_front();
         chk(e.to_vram == to_vram, e.req, "write port", {31'd0, to_vram}, {31'd0, e.to_vram});
         chk(e.addr == addr, e.req, "write addr", {16'd0, addr}, {16'd0, e.addr});
         chk(e.data == data, e.req, "write data", {16'd0, data}, {16'd0, e.data});
      end
   endtask

   // Monitor
   always @(negedge clk) begin
      if (rst_n) begin
         cyc_total++;
         if (bus_req) n_fetch++;
         if (vram_re) n_vrd++;
         if (fifo_we) begin n_fwr++; sb_check(1'b0, fifo_addr, fifo_wdata); end
         if (vram_we) begin n_vwr++; sb_check(1'b1, vram_waddr, {8'h00, vram_wdata}); end
      end
   end

   // Watchdog
   initial begin
      #(5.0 * 150000);
      n_fail++;
      $display("FAIL watchdog: run did not end, actual hung expected finished");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

   // Expected-item generators (from requirements R2, R4, R6, R7)
   task automatic exp_load(input logic [1:0] m, input logic [SRC_W-1:0] s,
                           input logic [15:0] d, input logic [7:0] inc, input int n, input string req);
      exp_t e;
      logic [SRC_W-1:0] sp = s;
      logic [15:0] dp = d;
      for (int i = 0; i < n; i++) begin
         e.to_vram = 0; e.addr = dp; e.data = bus_fn({m[0], sp, 1'b0}); e.req = req;
         sb_q.push_back(e);
         sp = {sp[SRC_W-1:16], sp[15:0] + 16'd1};
         dp = dp + {8'd0, inc};
      end
   endtask

   task automatic exp_fill(input logic [15:0] d, input logic [7:0] inc, input int n,
                           input logic [7:0] b, input string req);
      exp_t e;
      logic [15:0] dp = d;
      for (int i = 0; i < n; i++) begin
         e.to_vram = 1; e.addr = dp; e.data = {8'h00, b}; e.req = req;
         sb_q.push_back(e);
         dp = dp + {8'd0, inc};
      end
   endtask

   task automatic exp_copy(input logic [15:0] s, input logic [15:0] d, input logic [7:0] inc,
                           input int n, input string req);
      exp_t e;
      logic [15:0] sp = s, dp = d;
      for (int i = 0; i < n; i++) begin
         e.to_vram = 1; e.addr = dp ^ 16'd1; e.data = {8'h00, vram_fn(sp ^ 16'd1)}; e.req = req;
         sb_q.push_back(e);
         sp = sp + 16'd1;
         dp = dp + {8'd0, inc};
      end
   endtask

   // Called at a negedge; returns at the next negedge (first cycle after the start edge).
   task automatic kick_start(input logic [1:0] m, input logic [SRC_W-1:0] s, input logic [15:0] d,
                             input logic [7:0] inc, input logic [LEN_W-1:0] len);
      start_mode = m; start_src = s; start_dst = d; start_inc = inc; start_len = len;
      start_we = 1'b1;
      @(negedge clk);
      start_we = 1'b0;
   endtask

   task automatic wait_done(input int limit);
      int k = 0;
      while (!xfer_done && k < limit) begin @(negedge clk); k++; end
      chk(xfer_done, "R9", "done pulse seen", {31'd0, xfer_done}, 32'd1);
      chk(!xfer_pending, "R9", "pending low with done", {31'd0, xfer_pending}, 32'd0);
      @(negedge clk);
      chk(!xfer_done, "R9", "done lasts one cycle", {31'd0, xfer_done}, 32'd0);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   initial begin
      int cyc, f0, w0, r0, quiet;
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(!xfer_pending, "R1", "pending in reset", {31'd0, xfer_pending}, 32'd0);
      chk(!xfer_done, "R1", "done in reset", {31'd0, xfer_done}, 32'd0);
      rst_n = 1'b1;
      idle(3);
      chk(!(bus_req || fifo_we || vram_re || vram_we), "R1", "idle strobes",
          {28'd0, bus_req, fifo_we, vram_re, vram_we}, 32'd0);

      // T1: load mode 0 with source wrap (R2, R3, R7, R9)
      f0 = n_fetch;
      exp_load(2'd0, 22'h12FFFE, 16'h0100, 8'd2, 4, "R7");
      kick_start(2'd0, 22'h12FFFE, 16'h0100, 8'd2, 10'd4);
      chk(xfer_pending, "R9", "pending after start", {31'd0, xfer_pending}, 32'd1);
      cyc = 1;
      while (!fifo_we && cyc < 60) begin @(negedge clk); cyc++; end
      chk(cyc == 8, "R3", "first push cycle", cyc, 8);
      wait_done(200);
      chk(n_fetch - f0 == 4, "R2", "fetch count", n_fetch - f0, 4);

      // T2: load mode 1 held by a full queue (R2, R3)
      idle(2);
      fifo_full = 1'b1;
      f0 = n_fetch; w0 = n_fwr;
      exp_load(2'd1, 22'h001000, 16'h4000, 8'h20, 3, "R2");
      kick_start(2'd1, 22'h001000, 16'h4000, 8'h20, 10'd3);
      idle(20);
      chk(n_fwr == w0, "R3", "no push while full", n_fwr - w0, 0);
      chk(n_fetch - f0 == 1, "R2", "single held fetch", n_fetch - f0, 1);
      fifo_full = 1'b0;
      wait_done(200);
      chk(n_fetch - f0 == 3, "R2", "fetch count", n_fetch - f0, 3);

      // T3: fill waits for kick, then for empty queue and free RAM (R4, R5)
      idle(2);
      w0 = n_vwr;
      kick_start(2'd2, 22'h0, 16'h2000, 8'd1, 10'd3);
      idle(10);
      chk(n_vwr == w0, "R4", "no fill before kick", n_vwr - w0, 0);
      fifo_empty = 1'b0;
      exp_fill(16'h2000, 8'd1, 3, 8'hBE, "R4");
      fill_word = 16'hBEEF; fill_kick = 1'b1;
      @(negedge clk);
      fill_kick = 1'b0; fill_word = 16'h0000;
      idle(6);
      chk(n_vwr == w0, "R5", "no fill while queue busy", n_vwr - w0, 0);
      vram_busy = 1'b1; fifo_empty = 1'b1;
      idle(4);
      chk(n_vwr == w0, "R5", "no fill while RAM busy", n_vwr - w0, 0);
      vram_busy = 1'b0;
      wait_done(200);
      chk(n_vwr - w0 == 3, "R4", "fill count", n_vwr - w0, 3);

      // T4: copy held by busy RAM, then byte moves with XOR 1 (R6)
      idle(2);
      vram_busy = 1'b1;
      w0 = n_vwr; r0 = n_vrd;
      exp_copy(16'h0040, 16'h0300, 8'd1, 3, "R6");
      kick_start(2'd3, 22'h000040, 16'h0300, 8'd1, 10'd3);
      idle(6);
      chk((n_vwr == w0) && (n_vrd == r0), "R6", "no access while busy", (n_vwr - w0) + (n_vrd - r0), 0);
      vram_busy = 1'b0;
      wait_done(200);
      chk(n_vrd - r0 == 3, "R6", "copy read count", n_vrd - r0, 3);

      // T5: zero length runs 2^LEN_W fills (R8)
      idle(2);
      w0 = n_vwr;
      kick_start(2'd2, 22'h0, 16'h8000, 8'd1, 10'd0);
      exp_fill(16'h8000, 8'd1, 1 << LEN_W, 8'h7E, "R8");
      fill_word = 16'h7E00; fill_kick = 1'b1;
      @(negedge clk);
      fill_kick = 1'b0;
      wait_done(5000);
      chk(n_vwr - w0 == (1 << LEN_W), "R8", "zero-length count", n_vwr - w0, 1 << LEN_W);

      // T6: start collides with the final transfer (R10)
      idle(2);
      exp_load(2'd0, 22'h000200, 16'h0500, 8'd1, 1, "R10");
      kick_start(2'd0, 22'h000200, 16'h0500, 8'd1, 10'd1);
      quiet = 0;
      while (!fifo_we && quiet < 60) begin @(negedge clk); quiet++; end
      exp_load(2'd0, 22'h000300, 16'h0600, 8'd4, 2, "R10");
      kick_start(2'd0, 22'h000300, 16'h0600, 8'd4, 10'd2);
      chk(!xfer_done, "R10", "no done on overlap", {31'd0, xfer_done}, 32'd0);
      chk(xfer_pending, "R10", "pending kept", {31'd0, xfer_pending}, 32'd1);
      wait_done(200);

      idle(3);
      chk(sb_q.size() == 0, "R2", "scoreboard drained", sb_q.size(), 0);
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end
endmodule